// File: doc/BRIEF.md
# Write-Triggered Run Fill and Copy Engine

This engine sits on a register bus next to an 8-bit-per-pixel frame store and moves short runs of pixels on its own. Software first writes a colour word to any engine address whose bit 2 is clear. It then writes a trigger word to an address whose bit 2 is set. The trigger address carries the destination pixel index. The trigger data carries the source pixel index and the run length. A source value of all ones in the 24-bit source field means "fill with the colour" instead of "copy from the source".

The engine drives a simple synchronous memory port with separate read and write addresses. The read data comes back one cycle after the read enable. Next to the 8-bit plane, two 32-bit planes share the same pixel index: a deep-colour plane and a control plane. When the deep-colour mode input is set at trigger time, every pixel operation also touches the deep-colour plane. When the control-plane enable is also set, the control plane is touched as well. One pixel is handled per cycle. Copies run in ascending order and keep strict sequential semantics, so an overlapping forward copy replicates the pattern.

The register write port is valid/ready. While an operation runs, `wr_ready` is low. A write offered during that time, colour or trigger, stays pending with no effect until the engine is idle again. The master must hold `wr_valid`, `wr_addr` and `wr_data` stable until the write is accepted. Reads of the engine window are acknowledged one cycle later with zero data.

Top module: `blit_engine`

## Requirements
- R1: An accepted write with `wr_addr[2]`=0 stores `wr_data` as the colour word. It causes no memory write and does not set busy.
- R2: An accepted write with `wr_addr[2]`=1 starts an operation. The destination index is `wr_addr[AW+2:3]`. The source index is `wr_data[AW-1:0]` (the field is `wr_data[23:0]`). The run length is `wr_data[28:24]`+1, from 1 to 32. All pixel addresses wrap modulo 2^AW.
- R3: When `wr_data[23:0]` is 24'hFFFFFF, the run is filled: destination+i receives colour bits 7:0 for i = 0..len-1. One write is issued per cycle, starting the cycle after acceptance.
- R4: Otherwise the run is copied. The 8-bit plane takes the result of `dst+i := src+i` done in ascending i. Reads are issued one per cycle from the cycle after acceptance, and each write follows its read by one cycle. An overlapping forward copy therefore replicates data.
- R5: With deep mode set at trigger, a fill writes {8'h00, colour[23:0]} into the deep-colour plane and a copy copies its 32-bit words the same way. Without deep mode, that plane is not written.
- R6: The control plane gets the same fill value or copy as the deep-colour plane only when both deep mode and the control-plane enable are set at trigger. Otherwise it is not written.
- R7: `wr_ready` is low while busy. A stalled write is accepted only after the operation ends, and it does not alter the operation in flight.
- R8: `busy` rises in the cycle after the trigger is accepted. It stays high for len cycles on a fill and len+1 cycles on a copy. It falls one cycle after the last pixel write. `done` is a single-cycle pulse in the first cycle with busy low.
- R9: `rd_ack` follows `rd_req` by one cycle, and `rd_data` is zero.
- R10: After reset, `busy`, `done`, `rd_ack` and all memory enables are low, `wr_ready` is high, and the colour word is zero.
- R11: The mode inputs are sampled when the trigger is accepted. Changing them during an operation does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_deep | input | 1 | Deep-colour mode: also update the 32-bit deep plane |
| cfg_ctl | input | 1 | In deep mode, also update the control plane |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write accepted this cycle when valid |
| wr_addr | input | BAW | Byte address of the write within the engine window |
| wr_data | input | 32 | Write data: colour word or trigger word |
| rd_req | input | 1 | Read of the engine window |
| rd_ack | output | 1 | Read response, one cycle after request |
| rd_data | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| mem_re | output | 1 | Read enable of the pixel memory |
| mem_raddr | output | AW | Read pixel index |
| mem_rd8 | input | 8 | 8-bit plane read data, one cycle after mem_re |
| mem_rdw | input | 32 | Deep-colour plane read data |
| mem_rdc | input | 32 | Control plane read data |
| mem_we8 | output | 1 | 8-bit plane write enable |
| mem_we_w | output | 1 | Deep-colour plane write enable |
| mem_we_c | output | 1 | Control plane write enable |
| mem_waddr | output | AW | Write pixel index |
| mem_wd8 | output | 8 | 8-bit plane write data |
| mem_wdw | output | 32 | Deep-colour plane write data |
| mem_wdc | output | 32 | Control plane write data |

## Verification
The assertions assume the memory returns read data exactly one cycle after `mem_re`, and that a read issued in the same cycle as a write to the same index returns the old contents. The assertions also assume a write master that holds its request until `wr_ready`. The bench memory model follows both rules: reads of an index being written return the old value, so the engine's own forwarding is exercised. Every bus write waits for acceptance before dropping `wr_valid`. Mode inputs are changed only between operations, except in the test that flips them deliberately after a trigger to show they were captured.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int TRIG_BIT = 2;
  localparam int DST_LSB  = 3;
  localparam int SRC_W    = 24;
  localparam int LEN_LSB  = 24;
  localparam int LEN_W    = 5;
  localparam int CNT_W    = LEN_W + 1;

  typedef enum logic {
    OP_COPY = 1'b0,
    OP_FILL = 1'b1
  } op_kind_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int AW  = 20,
  parameter int BAW = AW + DST_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_deep,
  input  logic             cfg_ctl,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BAW-1:0]   wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_req,
  output logic             rd_ack,
  output logic [31:0]      rd_data,
  input  logic             busy,
  output logic             start,
  output op_kind_e         st_kind,
  output logic             st_deep,
  output logic             st_ctl,
  output logic [AW-1:0]    st_dst,
  output logic [AW-1:0]    st_src,
  output logic [CNT_W-1:0] st_cnt,
  output logic [23:0]      colour
);
  logic accept;
  logic is_trig;
  logic unused_bits;

  assign wr_ready = !busy;
  assign accept   = wr_valid && wr_ready;
  assign is_trig  = wr_addr[TRIG_BIT];
  assign start    = accept && is_trig;

  assign st_kind = (wr_data[SRC_W-1:0] == {SRC_W{1'b1}}) ? OP_FILL : OP_COPY;
  assign st_deep = cfg_deep;
  assign st_ctl  = cfg_ctl;
  assign st_dst  = wr_addr[DST_LSB +: AW];
  assign st_src  = wr_data[AW-1:0];
  assign st_cnt  = CNT_W'(wr_data[LEN_LSB +: LEN_W]) + CNT_W'(1);

  assign unused_bits = ^{wr_data[31:29], wr_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colour <= '0;
      rd_ack <= 1'b0;
    end else begin
      rd_ack <= rd_req;
      if (accept && !is_trig) colour <= wr_data[23:0];
    end
  end

  assign rd_data = '0;

  // R2: an accepted trigger makes the sequencer busy in the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R9: a response only follows a request
  a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_req));
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_kind_e         st_kind,
  input  logic             st_deep,
  input  logic             st_ctl,
  input  logic [AW-1:0]    st_dst,
  input  logic [AW-1:0]    st_src,
  input  logic [CNT_W-1:0] st_cnt,
  input  logic [23:0]      colour,
  output logic             busy,
  output logic             done,
  output logic             mem_re,
  output logic [AW-1:0]    mem_raddr,
  input  logic [7:0]       mem_rd8,
  input  logic [31:0]      mem_rdw,
  input  logic [31:0]      mem_rdc,
  output logic             mem_we8,
  output logic             mem_we_w,
  output logic             mem_we_c,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wd8,
  output logic [31:0]      mem_wdw,
  output logic [31:0]      mem_wdc
);
  op_kind_e         kind_q;
  logic             deep_q, ctl_q;
  logic [AW-1:0]    dst_q, src_q;
  logic [CNT_W-1:0] cnt_q, step, last_step, widx;
  logic [23:0]      col_q;
  logic             wr_phase;

  // forwarding of a write that collided with a read in the previous cycle
  logic             byp_hit;
  logic [7:0]       byp8;
  logic [31:0]      bypw, bypc;

  assign last_step = (kind_q == OP_FILL) ? cnt_q - CNT_W'(1) : cnt_q;

  assign mem_re    = busy && (kind_q == OP_COPY) && (step < cnt_q);
  assign mem_raddr = src_q + AW'(step);

  assign wr_phase  = busy && ((kind_q == OP_FILL) ? (step < cnt_q) : (step != '0));
  assign widx      = (kind_q == OP_FILL) ? step : step - CNT_W'(1);
  assign mem_waddr = dst_q + AW'(widx);

  assign mem_we8   = wr_phase;
  assign mem_we_w  = wr_phase && deep_q;
  assign mem_we_c  = wr_phase && deep_q && ctl_q;

  always_comb begin
    if (kind_q == OP_FILL) begin
      mem_wd8 = col_q[7:0];
      mem_wdw = {8'h00, col_q};
      mem_wdc = {8'h00, col_q};
    end else if (byp_hit) begin
      mem_wd8 = byp8;
      mem_wdw = bypw;
      mem_wdc = bypc;
    end else begin
      mem_wd8 = mem_rd8;
      mem_wdw = mem_rdw;
      mem_wdc = mem_rdc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      kind_q  <= OP_COPY;
      deep_q  <= 1'b0;
      ctl_q   <= 1'b0;
      dst_q   <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      col_q   <= '0;
      step    <= '0;
      byp_hit <= 1'b0;
      byp8    <= '0;
      bypw    <= '0;
      bypc    <= '0;
    end else begin
      done    <= busy && (step == last_step);
      byp_hit <= mem_re && mem_we8 && (mem_raddr == mem_waddr);
      byp8    <= mem_wd8;
      bypw    <= mem_wdw;
      bypc    <= mem_wdc;
      if (start) begin
        busy   <= 1'b1;
        kind_q <= st_kind;
        deep_q <= st_deep;
        ctl_q  <= st_ctl;
        dst_q  <= st_dst;
        src_q  <= st_src;
        cnt_q  <= st_cnt;
        col_q  <= colour;
        step   <= '0;
      end else if (busy) begin
        step <= step + CNT_W'(1);
        if (step == last_step) busy <= 1'b0;
      end
    end
  end

  // R8: done comes right after the busy period and lasts one cycle
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: consecutive pixel writes move to the next ascending index
  a_r3_write_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we8 && $past(mem_we8)) |-> (mem_waddr == $past(mem_waddr) + AW'(1)));

  // R4: consecutive copy reads move to the next ascending index
  a_r4_read_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_raddr == $past(mem_raddr) + AW'(1)));

  // R5: the deep plane is only written together with the 8-bit plane
  a_r5_deep_with_pix: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_w |-> mem_we8);

  // R6: the control plane is only written together with the deep plane
  a_r6_ctl_with_deep: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_c |-> mem_we_w);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int AW  = 20,
  parameter int BAW = AW + DST_LSB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_deep,
  input  logic           cfg_ctl,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [BAW-1:0] wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           rd_req,
  output logic           rd_ack,
  output logic [31:0]    rd_data,
  output logic           busy,
  output logic           done,
  output logic           mem_re,
  output logic [AW-1:0]  mem_raddr,
  input  logic [7:0]     mem_rd8,
  input  logic [31:0]    mem_rdw,
  input  logic [31:0]    mem_rdc,
  output logic           mem_we8,
  output logic           mem_we_w,
  output logic           mem_we_c,
  output logic [AW-1:0]  mem_waddr,
  output logic [7:0]     mem_wd8,
  output logic [31:0]    mem_wdw,
  output logic [31:0]    mem_wdc
);
  logic             start;
  op_kind_e         st_kind;
  logic             st_deep, st_ctl;
  logic [AW-1:0]    st_dst, st_src;
  logic [CNT_W-1:0] st_cnt;
  logic [23:0]      colour;

  blit_regs #(.AW(AW), .BAW(BAW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_deep (cfg_deep),
    .cfg_ctl  (cfg_ctl),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .busy     (busy),
    .start    (start),
    .st_kind  (st_kind),
    .st_deep  (st_deep),
    .st_ctl   (st_ctl),
    .st_dst   (st_dst),
    .st_src   (st_src),
    .st_cnt   (st_cnt),
    .colour   (colour)
  );

  blit_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .st_kind   (st_kind),
    .st_deep   (st_deep),
    .st_ctl    (st_ctl),
    .st_dst    (st_dst),
    .st_src    (st_src),
    .st_cnt    (st_cnt),
    .colour    (colour),
    .busy      (busy),
    .done      (done),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .mem_rd8   (mem_rd8),
    .mem_rdw   (mem_rdw),
    .mem_rdc   (mem_rdc),
    .mem_we8   (mem_we8),
    .mem_we_w  (mem_we_w),
    .mem_we_c  (mem_we_c),
    .mem_waddr (mem_waddr),
    .mem_wd8   (mem_wd8),
    .mem_wdw   (mem_wdw),
    .mem_wdc   (mem_wdc)
  );

  // R7: no write is accepted while an operation runs
  a_r7_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !wr_ready);
endmodule

// File: tb/sim_blit_engine.sv
module sim_blit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int BAW = 11;
  localparam int N   = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_deep = 1'b0, cfg_ctl = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [BAW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic rd_ack;
  logic [31:0] rd_data;
  logic busy, done;
  logic mem_re, mem_we8, mem_we_w, mem_we_c;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rd8, mem_wd8;
  logic [31:0] mem_rdw, mem_rdc, mem_wdw, mem_wdc;

  logic [7:0]  m8 [N];
  logic [31:0] mw [N];
  logic [31:0] mc [N];
  logic [7:0]  r8 [N];
  logic [31:0] rw [N];
  logic [31:0] rc [N];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_engine #(.AW(AW), .BAW(BAW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_ctl(cfg_ctl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_rd8(mem_rd8), .mem_rdw(mem_rdw), .mem_rdc(mem_rdc),
    .mem_we8(mem_we8), .mem_we_w(mem_we_w), .mem_we_c(mem_we_c),
    .mem_waddr(mem_waddr), .mem_wd8(mem_wd8), .mem_wdw(mem_wdw), .mem_wdc(mem_wdc)
  );

  // synchronous memory: read-during-write returns the old contents
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) begin
      mem_rd8 <= m8[mem_raddr];
      mem_rdw <= mw[mem_raddr];
      mem_rdc <= mc[mem_raddr];
    end
    if (mem_we8)  m8[mem_waddr] <= mem_wd8;
    if (mem_we_w) mw[mem_waddr] <= mem_wdw;
    if (mem_we_c) mc[mem_waddr] <= mem_wdc;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [BAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic compare_all(input string req);
    int bad8 = 0, badw = 0, badc = 0;
    int f8 = -1, fw = -1, fc = -1;
    for (int i = 0; i < N; i++) begin
      if (m8[i] !== r8[i]) begin bad8++; if (f8 < 0) f8 = i; end
      if (mw[i] !== rw[i]) begin badw++; if (fw < 0) fw = i; end
      if (mc[i] !== rc[i]) begin badc++; if (fc < 0) fc = i; end
    end
    if (bad8 == 0) chk(1, req, "pixel plane", 0, 0);
    else chk(0, req, $sformatf("pixel plane idx %0d", f8), m8[f8], r8[f8]);
    if (badw == 0) chk(1, "R5", "deep plane", 0, 0);
    else chk(0, "R5", $sformatf("deep plane idx %0d (%s)", fw, req), mw[fw], rw[fw]);
    if (badc == 0) chk(1, "R6", "control plane", 0, 0);
    else chk(0, "R6", $sformatf("control plane idx %0d (%s)", fc, req), mc[fc], rc[fc]);
  endtask

  task automatic ref_apply(input int dst, input int src24, input int len,
                           input logic [31:0] col, input bit deep, input bit ctl);
    for (int i = 0; i < len; i++) begin
      int d = (dst + i) % N;
      if (src24 == 24'hFFFFFF) begin
        r8[d] = col[7:0];
        if (deep) rw[d] = {8'h00, col[23:0]};
        if (deep && ctl) rc[d] = {8'h00, col[23:0]};
      end else begin
        int s = ((src24 % N) + i) % N;
        r8[d] = r8[s];
        if (deep) rw[d] = rw[s];
        if (deep && ctl) rc[d] = rc[s];
      end
    end
  endtask

  task automatic run_op(input int dst, input int src24, input int len,
                        input logic [31:0] col, input bit with_col,
                        input bit deep, input bit ctl, input bit flip,
                        input string req);
    int n = 0;
    int stall_bad = 0;
    int expn;
    cfg_deep = deep;
    cfg_ctl  = ctl;
    if (with_col) bus_write({dst[7:0], 3'b001}, col);
    bus_write({dst[7:0], 3'b100}, {3'b000, 5'(len - 1), 24'(src24)});
    chk(busy === 1'b1, "R8", $sformatf("busy after trigger (%s)", req), busy, 1);
    if (flip) begin
      cfg_deep = ~deep;
      cfg_ctl  = ~ctl;
    end
    while (busy && n < 100) begin
      if (wr_ready) stall_bad++;
      n++;
      @(negedge clk);
    end
    expn = (src24 == 24'hFFFFFF) ? len : len + 1;
    chk(n == expn, "R8", $sformatf("busy cycles len=%0d (%s)", len, req), n, expn);
    chk(stall_bad == 0, "R7", "wr_ready low while busy", stall_bad, 0);
    chk(done === 1'b1, "R8", "done in first idle cycle", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R8", "done lasts one cycle", done, 0);
    ref_apply(dst, src24, len, col, deep, ctl);
    compare_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cur_col;
    int t0;
    int koff [5] = '{-3, -1, 1, 2, 7};
    for (int i = 0; i < N; i++) begin
      m8[i] = 8'(i * 7 + 3);
      mw[i] = {8'(i), 8'(i ^ 85), 8'(i * 3), 8'(~i)};
      mc[i] = 32'h5A000000 + 32'(i * 13);
      r8[i] = m8[i];
      rw[i] = mw[i];
      rc[i] = mc[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(wr_ready === 1'b1, "R10", "wr_ready in reset", wr_ready, 1);
    chk(busy === 1'b0, "R10", "busy in reset", busy, 0);
    chk(done === 1'b0, "R10", "done in reset", done, 0);
    chk({mem_re, mem_we8, mem_we_w, mem_we_c} === 4'b0, "R10", "memory enables in reset",
        {mem_re, mem_we8, mem_we_w, mem_we_c}, 0);
    chk(rd_ack === 1'b0, "R10", "rd_ack in reset", rd_ack, 0);
    rst_n = 1'b1;

    // R10: colour word is zero after reset, seen through a fill without a colour write
    run_op(10, 24'hFFFFFF, 4, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R10");

    // R1: colour write alone touches no memory and does not start anything
    bus_write(11'h5A3, 32'h00C0FFEE);
    begin
      int act = 0;
      for (int i = 0; i < 4; i++) begin
        act += int'(busy) + int'(mem_we8) + int'(mem_re);
        @(negedge clk);
      end
      chk(act == 0, "R1", "activity after colour write", act, 0);
    end
    compare_all("R1");
    run_op(20, 24'hFFFFFF, 2, 32'h00C0FFEE, 1'b0, 1'b1, 1'b0, 1'b0, "R1");

    // R3: fill sweep over all lengths
    for (int l = 1; l <= 32; l++) begin
      cur_col = 32'hA5000000 | 32'(l * 32'h010203);
      run_op((l * 37) % N, 24'hFFFFFF, l, cur_col, 1'b1, l[0], l[1], 1'b0, "R3");
    end

    // R4: copy sweep over lengths and overlap offsets
    for (int l = 1; l <= 32; l++) begin
      for (int k = 0; k < 5; k++) begin
        int dd = 120 + koff[k];
        run_op(dd, 120, l, 32'h0, 1'b0, ((l + k) % 2) == 1, 1'b1, 1'b0, "R4");
      end
    end

    // R2: source field above AW bits is truncated, destination wraps
    run_op(250, 24'h123405, 12, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    run_op(252, 24'hFFFFFF, 9, 32'h00332211, 1'b1, 1'b0, 1'b0, 1'b0, "R2");

    // R11: modes captured at trigger, flipped right after
    run_op(60, 24'hFFFFFF, 8, 32'h00778899, 1'b1, 1'b1, 1'b1, 1'b1, "R11");
    run_op(70, 24'hFFFFFF, 8, 32'h00445566, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
    run_op(80, 60, 10, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, "R11");

    // R7: a colour write offered while busy waits and leaves the run unchanged
    cfg_deep = 1'b1;
    cfg_ctl  = 1'b1;
    bus_write(11'h000, 32'h00ABCDEF);
    bus_write({8'd200, 3'b100}, {3'b000, 5'd31, 24'hFFFFFF});
    t0 = cyc;
    bus_write(11'h000, 32'h00123456);
    chk((cyc - t0) >= 32, "R7", "stalled write accepted only after run", cyc - t0, 32);
    ref_apply(200, 24'hFFFFFF, 32, 32'h00ABCDEF, 1'b1, 1'b1);
    compare_all("R7");
    run_op(40, 24'hFFFFFF, 3, 32'h00123456, 1'b0, 1'b1, 1'b1, 1'b0, "R7");

    // R9: reads acknowledged one cycle later with zero data
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk(rd_ack === 1'b1, "R9", "rd_ack after request", rd_ack, 1);
      chk(rd_data === 32'h0, "R9", "read data", rd_data, 0);
      @(negedge clk);
      chk(rd_ack === 1'b0, "R9", "rd_ack drops", rd_ack, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule